// File: doc/BRIEF.md
# Transactional Store Buffer with Atomic Commit Burst

This block sits beside one processor's first-level cache and keeps every store made during a speculative transaction private to that processor. Each store names a line, a word inside the line and a byte mask. A store to a line that is already held merges into that line's entry. A store to a new line takes the next free entry, in allocation order. While the transaction runs, loads from the same processor look the buffer up first, so that buffered bytes take precedence over cache data. Nothing the buffer holds is visible outside it.

When the transaction ends, the buffer stops taking stores and waits for a commit grant. Once the grant arrives, it sends its whole contents as one contiguous packet: one beat per entry under a valid/ready handshake, with the first beat marked start and the last marked end. The beat format follows two mode inputs. Invalidate mode carries only line addresses. Update mode also carries the data, and can send either full lines or only the words that were actually written. An abort before the packet starts throws all entries away so that the transaction can restart clean. When the last beat has been taken, the buffer empties and pulses a done flag.

Top module: `txn_wbuf`

## Requirements
- R1: After reset the buffer is empty and open. st_ready_o is 1, pkt_valid_o, ovf_o and commit_done_o are 0, and every load lookup misses (ld_hit_o=0, ld_data_o=0, ld_be_o=0).
- R2: No beat leaves the buffer before a commit grant that is sampled after the transaction end. A grant while the buffer is open has no effect, and pkt_valid_o stays 0 whenever stores are being accepted.
- R3: A store to a line already held merges its enabled bytes into that entry and allocates nothing. When all DEPTH entries hold distinct lines, a store to a new line is refused (st_ready_o=0) and ovf_o=1 for as long as it is offered, while stores to held lines are still accepted.
- R4: A load lookup that names a held line returns ld_hit_o=1, the word's written bytes in ld_be_o (bit b = byte b of the word), and those bytes in ld_data_o, with unwritten bytes 0. Byte b of a word occupies bits [8b+7:8b], and word w of a line occupies line bits [w*WORD_W +: WORD_W].
- R5: From the cycle after txn_end_i is accepted until the commit finishes or an abort arrives, st_ready_o is 0 and no store is taken.
- R6: The packet has exactly one beat per entry, in allocation order. pkt_sop_o is set only on the first beat and pkt_eop_o only on the last. A beat that is offered but not accepted is held unchanged.
- R7: With mode_upd_i=0 (invalidate), each beat carries its line address with pkt_data_o, pkt_be_o and pkt_wmask_o all 0.
- R8: With mode_upd_i=1 and dirty_only_i=0, each beat carries the line address, the merged line data (unwritten bytes 0), the line byte mask in pkt_be_o, and pkt_wmask_o all ones (bit w = word w).
- R9: With mode_upd_i=1 and dirty_only_i=1, bit w of pkt_wmask_o is 1 exactly when word w holds at least one written byte. Data and byte mask are as in R8.
- R10: An abort while the buffer is open or waiting for the grant discards all entries. The buffer then reopens, later loads miss, and a following commit sends no beat. A store offered in the same cycle as the abort is refused.
- R11: commit_done_o is 1 for exactly the one cycle after the last beat is accepted, and the buffer is then empty and open. A commit of an empty buffer sends no beat and raises commit_done_o in the cycle after the grant.
- R12: An abort that arrives while the packet is being sent is ignored, and every remaining beat is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered |
| st_line_i | input | LINE_AW | Store line address |
| st_word_i | input | WI_W | Word index within the line |
| st_data_i | input | WORD_W | Store word data |
| st_be_i | input | WORD_W/8 | Store byte enables |
| st_ready_o | output | 1 | Store accepted this cycle |
| ovf_o | output | 1 | Store to a new line refused because the buffer is full |
| ld_line_i | input | LINE_AW | Load lookup line address |
| ld_word_i | input | WI_W | Load lookup word index |
| ld_hit_o | output | 1 | Line held in buffer |
| ld_data_o | output | WORD_W | Buffered word bytes |
| ld_be_o | output | WORD_W/8 | Which bytes of the word are buffered |
| txn_end_i | input | 1 | Transaction end |
| commit_gnt_i | input | 1 | Commit grant from arbitration |
| abort_i | input | 1 | Violation rollback |
| mode_upd_i | input | 1 | 1 = update beats with data, 0 = address-only invalidate |
| dirty_only_i | input | 1 | In update mode, mark only written words |
| pkt_valid_o | output | 1 | Packet beat valid |
| pkt_ready_i | input | 1 | Packet beat accepted |
| pkt_sop_o | output | 1 | First beat of packet |
| pkt_eop_o | output | 1 | Last beat of packet |
| pkt_line_o | output | LINE_AW | Beat line address |
| pkt_data_o | output | WORDS*WORD_W | Beat line data |
| pkt_be_o | output | WORDS*WORD_W/8 | Beat byte mask |
| pkt_wmask_o | output | WORDS | Beat word-present mask |
| commit_done_o | output | 1 | One-cycle pulse when commit completes |

## Verification
The store pattern is varied in several ways. Repeated partial-mask stores to a few lines separate merging from allocation, and forwarded loads show which bytes landed. A sweep of sixteen distinct lines followed by a new line and a held line separates the overflow stall from coalescing. Words written on only one half of a line separate the dirty-only mask from the full mask. The same buffered contents are committed in each broadcast mode, under steady and irregular ready patterns, to check beat ordering and hold. Aborts are placed before the grant, during the wait and during the burst, and an empty commit is included, so that discarding can be told apart from an ignored rollback.

// File: rtl/txn_wbuf_pkg.sv
package txn_wbuf_pkg;
  typedef enum logic [1:0] {
    WB_OPEN = 2'd0,
    WB_WAIT = 2'd1,
    WB_SEND = 2'd2
  } wb_state_e;
endpackage

// File: rtl/txn_wbuf_cam.sv
module txn_wbuf_cam #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] ent_vld_i,
  input  logic [TAG_W-1:0] tags_i [DEPTH],
  input  logic [TAG_W-1:0] key_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = ent_vld_i[i] && (tags_i[i] == key_i);
  end

  assign hit_o = |match;

  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/txn_wbuf_fmt.sv
module txn_wbuf_fmt #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int WB     = WORD_W / 8,
  localparam int LINE_B = WORDS * WB,
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              mode_upd_i,
  input  logic              dirty_only_i,
  input  logic [LINE_W-1:0] line_data_i,
  input  logic [LINE_B-1:0] line_be_i,
  output logic [LINE_W-1:0] data_o,
  output logic [LINE_B-1:0] be_o,
  output logic [WORDS-1:0]  wmask_o
);
  logic [WORDS-1:0] dirty;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign dirty[w] = |line_be_i[w*WB +: WB];
  end

  always_comb begin
    data_o  = '0;
    be_o    = '0;
    wmask_o = '0;
    if (mode_upd_i) begin
      data_o  = line_data_i;
      be_o    = line_be_i;
      wmask_o = dirty_only_i ? dirty : '1;
    end
  end
endmodule

// File: rtl/txn_wbuf_ctrl.sv
module txn_wbuf_ctrl
  import txn_wbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             txn_end_i,
  input  logic             commit_gnt_i,
  input  logic             abort_i,
  input  logic             alloc_i,
  input  logic             beat_fire_i,
  output wb_state_e        state_o,
  output logic [CNT_W-1:0] count_o,
  output logic [IDX_W-1:0] rd_ptr_o,
  output logic             last_o,
  output logic             commit_done_o
);
  wb_state_e        state_q, state_d;
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] rd_ptr_q;
  logic             done_q, done_d, clear;

  assign last_o = (CNT_W'(rd_ptr_q) + CNT_W'(1)) == count_q;

  always_comb begin
    state_d = state_q;
    clear   = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      WB_OPEN: begin
        if (abort_i) clear = 1'b1;
        else if (txn_end_i) state_d = WB_WAIT;
      end
      WB_WAIT: begin
        if (abort_i) begin
          clear   = 1'b1;
          state_d = WB_OPEN;
        end else if (commit_gnt_i) begin
          if (count_q == '0) begin
            state_d = WB_OPEN;
            done_d  = 1'b1;
          end else begin
            state_d = WB_SEND;
          end
        end
      end
      WB_SEND: begin
        // rollback cannot interrupt a granted commit
        if (beat_fire_i && last_o) begin
          state_d = WB_OPEN;
          clear   = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = WB_OPEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= WB_OPEN;
      count_q  <= '0;
      rd_ptr_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (clear) count_q <= '0;
      else if (alloc_i) count_q <= count_q + CNT_W'(1);
      if (state_q != WB_SEND) rd_ptr_q <= '0;
      else if (beat_fire_i) rd_ptr_q <= rd_ptr_q + IDX_W'(1);
    end
  end

  assign state_o       = state_q;
  assign count_o       = count_q;
  assign rd_ptr_o      = rd_ptr_q;
  assign commit_done_o = done_q;
endmodule

// File: rtl/txn_wbuf.sv
module txn_wbuf
  import txn_wbuf_pkg::*;
#(
  parameter int LINE_AW = 8,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  parameter int DEPTH   = 16,
  localparam int WB     = WORD_W / 8,
  localparam int LINE_B = WORDS * WB,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int WI_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               st_valid_i,
  input  logic [LINE_AW-1:0] st_line_i,
  input  logic [WI_W-1:0]    st_word_i,
  input  logic [WORD_W-1:0]  st_data_i,
  input  logic [WB-1:0]      st_be_i,
  output logic               st_ready_o,
  output logic               ovf_o,
  input  logic [LINE_AW-1:0] ld_line_i,
  input  logic [WI_W-1:0]    ld_word_i,
  output logic               ld_hit_o,
  output logic [WORD_W-1:0]  ld_data_o,
  output logic [WB-1:0]      ld_be_o,
  input  logic               txn_end_i,
  input  logic               commit_gnt_i,
  input  logic               abort_i,
  input  logic               mode_upd_i,
  input  logic               dirty_only_i,
  output logic               pkt_valid_o,
  input  logic               pkt_ready_i,
  output logic               pkt_sop_o,
  output logic               pkt_eop_o,
  output logic [LINE_AW-1:0] pkt_line_o,
  output logic [LINE_W-1:0]  pkt_data_o,
  output logic [LINE_B-1:0]  pkt_be_o,
  output logic [WORDS-1:0]   pkt_wmask_o,
  output logic               commit_done_o
);
  wb_state_e        state;
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] rd_ptr;
  logic             last;

  logic [LINE_AW-1:0] tag_a  [DEPTH];
  logic [LINE_W-1:0]  data_a [DEPTH];
  logic [LINE_B-1:0]  be_a   [DEPTH];
  logic [DEPTH-1:0]   ent_vld;

  logic             st_hit, ld_hit, st_fire, full, beat_fire;
  logic [IDX_W-1:0] st_idx, ld_idx, wr_idx;
  logic [LINE_B-1:0] line_wbe;
  logic [LINE_W-1:0] line_wdata, line_wbits;

  for (genvar i = 0; i < DEPTH; i++) begin : g_vld
    assign ent_vld[i] = CNT_W'(i) < count;
  end

  txn_wbuf_cam #(.DEPTH(DEPTH), .TAG_W(LINE_AW)) u_st_cam (
    .ent_vld_i(ent_vld), .tags_i(tag_a), .key_i(st_line_i),
    .hit_o(st_hit), .idx_o(st_idx)
  );

  txn_wbuf_cam #(.DEPTH(DEPTH), .TAG_W(LINE_AW)) u_ld_cam (
    .ent_vld_i(ent_vld), .tags_i(tag_a), .key_i(ld_line_i),
    .hit_o(ld_hit), .idx_o(ld_idx)
  );

  assign full       = count == CNT_W'(DEPTH);
  assign st_ready_o = (state == WB_OPEN) && !abort_i && (st_hit || !full);
  assign ovf_o      = (state == WB_OPEN) && st_valid_i && !st_hit && full;
  assign st_fire    = st_valid_i && st_ready_o;
  assign wr_idx     = st_hit ? st_idx : count[IDX_W-1:0];

  // place the store word into line position
  always_comb begin
    line_wbe   = '0;
    line_wdata = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (st_word_i == WI_W'(w)) begin
        line_wbe[w*WB +: WB]       = st_be_i;
        line_wdata[w*WORD_W +: WORD_W] = st_data_i;
      end
    end
    for (int b = 0; b < LINE_B; b++) begin
      line_wbits[b*8 +: 8] = {8{line_wbe[b]}};
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [LINE_AW-1:0] tag_q;
    logic [LINE_W-1:0]  data_q;
    logic [LINE_B-1:0]  be_q;
    logic               wr_en;

    assign wr_en = st_fire && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q  <= '0;
        data_q <= '0;
        be_q   <= '0;
      end else if (wr_en) begin
        if (st_hit) begin
          be_q   <= be_q | line_wbe;
          data_q <= (data_q & ~line_wbits) | (line_wdata & line_wbits);
        end else begin
          tag_q  <= st_line_i;
          be_q   <= line_wbe;
          data_q <= line_wdata & line_wbits;
        end
      end
    end

    assign tag_a[i]  = tag_q;
    assign data_a[i] = data_q;
    assign be_a[i]   = be_q;
  end

  // forwarding
  always_comb begin
    ld_data_o = '0;
    ld_be_o   = '0;
    if (ld_hit) begin
      for (int w = 0; w < WORDS; w++) begin
        if (ld_word_i == WI_W'(w)) begin
          ld_data_o = data_a[ld_idx][w*WORD_W +: WORD_W];
          ld_be_o   = be_a[ld_idx][w*WB +: WB];
        end
      end
    end
  end
  assign ld_hit_o = ld_hit;

  assign pkt_valid_o = state == WB_SEND;
  assign beat_fire   = pkt_valid_o && pkt_ready_i;
  assign pkt_sop_o   = pkt_valid_o && (rd_ptr == '0);
  assign pkt_eop_o   = pkt_valid_o && last;
  assign pkt_line_o  = pkt_valid_o ? tag_a[rd_ptr] : '0;

  txn_wbuf_fmt #(.WORDS(WORDS), .WORD_W(WORD_W)) u_fmt (
    .mode_upd_i  (mode_upd_i && pkt_valid_o),
    .dirty_only_i(dirty_only_i),
    .line_data_i (data_a[rd_ptr]),
    .line_be_i   (be_a[rd_ptr]),
    .data_o      (pkt_data_o),
    .be_o        (pkt_be_o),
    .wmask_o     (pkt_wmask_o)
  );

  txn_wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .txn_end_i    (txn_end_i),
    .commit_gnt_i (commit_gnt_i),
    .abort_i      (abort_i),
    .alloc_i      (st_fire && !st_hit),
    .beat_fire_i  (beat_fire),
    .state_o      (state),
    .count_o      (count),
    .rd_ptr_o     (rd_ptr),
    .last_o       (last),
    .commit_done_o(commit_done_o)
  );
endmodule

// File: rtl/txn_wbuf_chk.sv
module txn_wbuf_chk #(
  parameter int LINE_AW = 8,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  localparam int LINE_B = WORDS * (WORD_W / 8)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               st_valid_i,
  input logic               st_ready_o,
  input logic               ovf_o,
  input logic               txn_end_i,
  input logic               commit_gnt_i,
  input logic               mode_upd_i,
  input logic               dirty_only_i,
  input logic               pkt_valid_o,
  input logic               pkt_ready_i,
  input logic               pkt_sop_o,
  input logic               pkt_eop_o,
  input logic [LINE_AW-1:0] pkt_line_o,
  input logic [LINE_B-1:0]  pkt_be_o,
  input logic [WORDS-1:0]   pkt_wmask_o,
  input logic               commit_done_o
);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> st_valid_i && !st_ready_o);

  p_private_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ready_o |-> !pkt_valid_o);

  p_start_after_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_valid_o) |-> pkt_sop_o && $past(commit_gnt_i));

  p_stall_after_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_end_i && st_ready_o |=> !st_ready_o);

  p_beat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_line_o)
      && $stable(pkt_sop_o) && $stable(pkt_eop_o));

  p_inval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !mode_upd_i |-> pkt_wmask_o == '0 && pkt_be_o == '0);

  p_full_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && mode_upd_i && !dirty_only_i |-> &pkt_wmask_o);

  p_done_after_eop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && pkt_ready_i && pkt_eop_o |=> commit_done_o && !pkt_valid_o);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_done_o |=> !commit_done_o);
endmodule

bind txn_wbuf txn_wbuf_chk #(
  .LINE_AW(LINE_AW), .WORDS(WORDS), .WORD_W(WORD_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_valid_i(st_valid_i), .st_ready_o(st_ready_o),
  .ovf_o(ovf_o), .txn_end_i(txn_end_i), .commit_gnt_i(commit_gnt_i),
  .mode_upd_i(mode_upd_i), .dirty_only_i(dirty_only_i), .pkt_valid_o(pkt_valid_o),
  .pkt_ready_i(pkt_ready_i), .pkt_sop_o(pkt_sop_o), .pkt_eop_o(pkt_eop_o),
  .pkt_line_o(pkt_line_o), .pkt_be_o(pkt_be_o), .pkt_wmask_o(pkt_wmask_o),
  .commit_done_o(commit_done_o)
);

// File: tb/txn_wbuf_tb_top.sv
`timescale 1ns/1ps
module txn_wbuf_tb_top;
  localparam int LAW = 6, NW = 2, WW = 16, DEP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, st_ready, ovf;
  logic [LAW-1:0] st_line = '0, ld_line = '0;
  logic st_word = 0, ld_word = 0;
  logic [WW-1:0] st_data = '0, ld_data;
  logic [1:0] st_be = '0, ld_be;
  logic ld_hit, txn_end = 0, gnt = 0, abort = 0, mode_upd = 0, dirty_only = 0;
  logic pkt_valid, pkt_ready = 0, sop, eop, done;
  logic [LAW-1:0] pkt_line;
  logic [31:0] pkt_data;
  logic [3:0] pkt_be;
  logic [1:0] pkt_wmask;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [LAW-1:0] m_tag [DEP];
  logic [31:0]    m_dat [DEP];
  logic [3:0]     m_be  [DEP];
  int m_n = 0;

  always #2.5 clk = ~clk;

  txn_wbuf #(.LINE_AW(LAW), .WORDS(NW), .WORD_W(WW), .DEPTH(DEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_line_i(st_line), .st_word_i(st_word),
    .st_data_i(st_data), .st_be_i(st_be), .st_ready_o(st_ready), .ovf_o(ovf),
    .ld_line_i(ld_line), .ld_word_i(ld_word), .ld_hit_o(ld_hit),
    .ld_data_o(ld_data), .ld_be_o(ld_be),
    .txn_end_i(txn_end), .commit_gnt_i(gnt), .abort_i(abort),
    .mode_upd_i(mode_upd), .dirty_only_i(dirty_only),
    .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready), .pkt_sop_o(sop), .pkt_eop_o(eop),
    .pkt_line_o(pkt_line), .pkt_data_o(pkt_data), .pkt_be_o(pkt_be),
    .pkt_wmask_o(pkt_wmask), .commit_done_o(done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [LAW-1:0] line);
    for (int i = 0; i < m_n; i++) if (m_tag[i] == line) return i;
    return -1;
  endfunction

  // starts and ends just after a falling edge
  task automatic store(input logic [LAW-1:0] line, input logic w, input logic [15:0] d,
                       input logic [1:0] be, input bit ab);
    int idx = find(line);
    bit acc = !ab && (idx >= 0 || m_n < DEP);
    st_valid = 1; st_line = line; st_word = w; st_data = d; st_be = be; abort = ab;
    #1;
    check(ab ? "R10 store refused on abort" : "R3 store accept", st_ready, acc);
    check("R3 overflow flag", ovf, !ab && idx < 0 && m_n == DEP);
    @(posedge clk);
    if (ab) m_n = 0;
    else if (acc) begin
      if (idx < 0) begin
        idx = m_n; m_n++;
        m_tag[idx] = line; m_dat[idx] = '0; m_be[idx] = '0;
      end
      for (int b = 0; b < 2; b++) if (be[b]) begin
        m_dat[idx][(w*2+b)*8 +: 8] = d[b*8 +: 8];
        m_be[idx][w*2+b] = 1'b1;
      end
    end
    @(negedge clk);
    st_valid = 0; abort = 0;
  endtask

  task automatic load_chk(input logic [LAW-1:0] line, input logic w);
    int idx = find(line);
    logic [1:0] eb = (idx >= 0) ? m_be[idx][w*2 +: 2] : 2'b00;
    logic [15:0] ed = (idx >= 0) ? m_dat[idx][w*16 +: 16] : 16'h0;
    ld_line = line; ld_word = w;
    #1;
    check("R4 load hit", ld_hit, idx >= 0);
    check("R4 load be", ld_be, eb);
    check("R4 load data", ld_data, ed);
  endtask

  task automatic commit(input bit upd, input bit dty, input bit bp, input bit ab_mid);
    int k = 0, cyc = 0;
    mode_upd = upd; dirty_only = dty;
    txn_end = 1;
    @(posedge clk); @(negedge clk);
    txn_end = 0;
    st_valid = 1; st_line = 6'd63; st_be = 2'b11;
    #1;
    check("R5 stores stalled after end", st_ready, 0);
    check("R2 no beat before grant", pkt_valid, 0);
    @(posedge clk); @(negedge clk);
    st_valid = 0;
    gnt = 1;
    @(posedge clk); @(negedge clk);
    gnt = 0;
    if (m_n == 0) begin
      check("R11 empty commit done", done, 1);
      check("R11 empty commit no beat", pkt_valid, 0);
    end else begin
      while (k < m_n && cyc < 400) begin
        logic [1:0] ewm;
        pkt_ready = bp ? ((cyc % 3) != 1) : 1'b1;
        abort = ab_mid && (k == 1);
        #1;
        check("R6 beat valid", pkt_valid, 1);
        if (pkt_ready) begin
          ewm = !upd ? 2'b00 : dty ? {|m_be[k][3:2], |m_be[k][1:0]} : 2'b11;
          check("R6 beat line order", pkt_line, m_tag[k]);
          check("R6 sop", sop, k == 0);
          check("R6 eop", eop, k == m_n - 1);
          check(upd ? "R8 beat data" : "R7 beat data", pkt_data, upd ? m_dat[k] : 32'h0);
          check(upd ? "R8 beat be" : "R7 beat be", pkt_be, upd ? m_be[k] : 4'h0);
          check(!upd ? "R7 wmask" : dty ? "R9 wmask" : "R8 wmask", pkt_wmask, ewm);
          k++;
        end
        cyc++;
        @(posedge clk); @(negedge clk);
        abort = 0;
      end
      pkt_ready = 0;
      check(ab_mid ? "R12 all beats after abort" : "R6 beat count", k, m_n);
      check("R11 done after last beat", done, 1);
      check("R11 valid drops", pkt_valid, 0);
    end
    m_n = 0;
    #1;
    check("R11 reopen", st_ready, 1);
    @(posedge clk); @(negedge clk);
    check("R11 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset ready", st_ready, 1);
    check("R1 reset valid", pkt_valid, 0);
    check("R1 reset done", done, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ovf", ovf, 0);
    load_chk(6'd5, 0);

    // partial merges
    store(6'd5, 0, 16'h1111, 2'b01, 0);
    store(6'd9, 1, 16'h2233, 2'b11, 0);
    store(6'd5, 0, 16'hAB00, 2'b10, 0);
    store(6'd12, 1, 16'h4455, 2'b10, 0);
    store(6'd5, 1, 16'h6677, 2'b01, 0);
    store(6'd9, 1, 16'h8899, 2'b01, 0);
    check("R3 coalesced entry count", m_n, 3);
    for (int l = 0; l < 64; l += 1) begin
      if (l == 5 || l == 9 || l == 12 || l == 40) begin
        load_chk(6'(l), 0);
        load_chk(6'(l), 1);
      end
    end
    // grant while open is ignored
    gnt = 1;
    @(posedge clk); @(negedge clk);
    gnt = 0;
    check("R2 grant while open ignored", pkt_valid, 0);
    check("R2 still open", st_ready, 1);
    commit(1, 0, 0, 0);
    load_chk(6'd5, 0);

    // fill, overflow, coalesce while full
    for (int i = 0; i < DEP; i++)
      store(6'((i * 7 + 2) % 64), 1'(i % 2), 16'(i * 16'h0913 + 16'h0101), 2'b11, 0);
    store(6'd63, 0, 16'hDEAD, 2'b11, 0);
    store(6'd16, 1, 16'h00C3, 2'b01, 0);
    load_chk(6'd16, 1);
    load_chk(6'd63, 0);
    commit(0, 0, 1, 0);

    // dirty-only
    store(6'd20, 0, 16'h1357, 2'b11, 0);
    store(6'd21, 1, 16'h2468, 2'b10, 0);
    store(6'd22, 0, 16'h0F0F, 2'b01, 0);
    store(6'd22, 1, 16'hF0F0, 2'b10, 0);
    store(6'd23, 1, 16'h5A5A, 2'b11, 0);
    commit(1, 1, 1, 0);

    // abort while open, then empty commit
    store(6'd30, 0, 16'h7777, 2'b11, 0);
    store(6'd31, 1, 16'h8888, 2'b11, 0);
    store(6'd32, 0, 16'h9999, 2'b11, 1);
    load_chk(6'd30, 0);
    load_chk(6'd31, 1);
    load_chk(6'd32, 0);
    commit(1, 0, 0, 0);

    // abort while waiting for grant
    store(6'd40, 0, 16'hCAFE, 2'b11, 0);
    txn_end = 1;
    @(posedge clk); @(negedge clk);
    txn_end = 0; abort = 1;
    @(posedge clk); @(negedge clk);
    abort = 0; m_n = 0;
    #1;
    check("R10 reopen after abort in wait", st_ready, 1);
    load_chk(6'd40, 0);

    // abort during burst ignored
    for (int i = 0; i < 5; i++)
      store(6'(i * 11 + 1), 1'(i % 2), 16'(i * 16'h1111 + 16'h0A0B), 2'(i % 3 + 1), 0);
    commit(1, 0, 1, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule